// File: doc/BRIEF.md
# Two-Bit Gray-Order Step Counter with Clear

This block is a two-bit synchronous counter whose state register moves through a reflected Gray order instead of binary order, so every advance flips exactly one state bit. An advance input steps the counter, a synchronous clear returns it to zero, and with neither asserted the state holds. When clear and advance arrive together, clear takes precedence. This gives every state exactly one successor for every input pattern, and no input combination is left undefined.

The four states are ST_ZERO (00), ST_ONE (01), ST_TWO (11) and ST_THREE (10). The named transitions are:
- ADVANCE: ST_ZERO→ST_ONE→ST_TWO→ST_THREE→ST_ZERO.
- IDLE: each state returns to itself.
- CLEAR: any state goes to ST_ZERO.

Two flags come out of the block:
- The terminal flag is a Moore output. It depends on the state alone and is high only in ST_TWO.
- The mid-point flag is a Mealy output. It is high only in ST_ONE while the qualifier input is high, and it follows the qualifier within the same cycle.

An active-low power-on reset forces ST_ZERO.

Top module: `gray_step_ctr`

## Requirements
- R1: While the active-low reset is low, and on the first cycle after it is released, the state is 00 and both flags are low.
- R2: With clear low and advance high, the state moves on each rising edge in the order 00, 01, 11, 10 and then back to 00.
- R3: With clear low and advance low, the state keeps its current value across a rising edge.
- R4: With clear high at a rising edge, the state becomes 00 after that edge, whatever the previous state was.
- R5: When clear and advance are both high at an edge, the state becomes 00; advance has no effect.
- R6: Every advance step changes exactly one of the two state bits.
- R7: The terminal flag is high exactly when the state is 11, and the qualifier input has no effect on it.
- R8: The mid-point flag is high exactly when the state is 01 and the qualifier input is high, and it responds to the qualifier in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_n_i | input | 1 | Active-low power-on reset, forces state 00 |
| clr_i | input | 1 | Synchronous clear, highest priority |
| adv_i | input | 1 | Advance enable |
| qual_i | input | 1 | Qualifier for the mid-point flag |
| state_o | output | 2 | Current Gray-coded state |
| last_o | output | 1 | Moore terminal flag (state 11) |
| mid_o | output | 1 | Mealy mid-point flag (state 01 and qualifier) |

## Verification
The bench drives clear together with advance from every state. A design that gave advance priority would step to the next Gray value instead of returning to 00. It walks the full ADVANCE loop twice and compares each step against both the expected order and a one-bit-change rule. This exposes a binary-order design, which goes to 10 after 01 and flips two bits at 01→10, and it also exposes a wrong wraparound. It toggles the qualifier in every state without a clock edge between toggles. A mid-point flag that was registered, or that was decoded from the wrong state, would then lag the qualifier or appear in the wrong state. A terminal flag that depended on the qualifier would change when the qualifier changed. Idle cycles in each state catch a design that drifts when advance is low.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO  = 2'b00,
        ST_ONE   = 2'b01,
        ST_TWO   = 2'b11,
        ST_THREE = 2'b10
    } gsc_state_t;

    localparam gsc_state_t RESET_STATE = ST_ZERO;
    localparam gsc_state_t TERM_STATE  = ST_TWO;
    localparam gsc_state_t MID_STATE   = ST_ONE;
endpackage

// File: rtl/gsc_next.sv
module gsc_next
    import gsc_pkg::*;
(
    input  gsc_state_t cur_i,
    input  logic       clr_i,
    input  logic       adv_i,
    output gsc_state_t nxt_o
);
    gsc_state_t step_s;

    // ADVANCE successor in reflected Gray order
    always_comb begin
        unique case (cur_i)
            ST_ZERO:  step_s = ST_ONE;
            ST_ONE:   step_s = ST_TWO;
            ST_TWO:   step_s = ST_THREE;
            ST_THREE: step_s = ST_ZERO;
            default:  step_s = RESET_STATE;
        endcase
    end

    // Fixed priority: CLEAR over ADVANCE over IDLE
    always_comb begin
        if (clr_i) begin
            nxt_o = RESET_STATE;
        end else if (adv_i) begin
            nxt_o = step_s;
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/gsc_state_reg.sv
module gsc_state_reg
    import gsc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_n_i,
    input  logic       clr_i,
    input  logic       adv_i,
    input  gsc_state_t nxt_i,
    output gsc_state_t cur_o
);
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cur_o <= RESET_STATE;
        end else begin
            cur_o <= nxt_i;
        end
    end

    p_clear_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clr_i |=> (cur_o == ST_ZERO));

    p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (clr_i && adv_i) |=> (cur_o == ST_ZERO));

    p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_i && !adv_i) |=> $stable(cur_o));

    p_one_bit_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_i && adv_i) |=> ($countones(cur_o ^ $past(cur_o)) == 1));

    p_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_i && adv_i && cur_o == ST_THREE) |=> (cur_o == ST_ZERO));

    p_first_step_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (!clr_i && adv_i && cur_o == ST_ZERO) |=> (cur_o == ST_ONE));
endmodule

// File: rtl/gsc_flags.sv
module gsc_flags
    import gsc_pkg::*;
(
    input  gsc_state_t cur_i,
    input  logic       qual_i,
    output logic       last_o,
    output logic       mid_o
);
    always_comb begin
        last_o = 1'b0;
        mid_o  = 1'b0;
        unique case (cur_i)
            ST_ZERO:  ;
            ST_ONE:   mid_o  = qual_i;
            ST_TWO:   last_o = 1'b1;
            ST_THREE: ;
            default:  ;
        endcase
    end
endmodule

// File: rtl/gray_step_ctr.sv
module gray_step_ctr
    import gsc_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_n_i,
    input  logic               clr_i,
    input  logic               adv_i,
    input  logic               qual_i,
    output logic [STATE_W-1:0] state_o,
    output logic               last_o,
    output logic               mid_o
);
    gsc_state_t cur_s;
    gsc_state_t nxt_s;

    gsc_next u_next (
        .cur_i (cur_s),
        .clr_i (clr_i),
        .adv_i (adv_i),
        .nxt_o (nxt_s)
    );

    gsc_state_reg u_reg (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .clr_i   (clr_i),
        .adv_i   (adv_i),
        .nxt_i   (nxt_s),
        .cur_o   (cur_s)
    );

    gsc_flags u_flags (
        .cur_i  (cur_s),
        .qual_i (qual_i),
        .last_o (last_o),
        .mid_o  (mid_o)
    );

    assign state_o = cur_s;

    p_last_only_eleven_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        last_o |-> (state_o == 2'b11));

    p_mid_needs_qual_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        mid_o |-> (qual_i && state_o == 2'b01));

    p_flags_exclusive_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !(last_o && mid_o));
endmodule

// File: tb/gray_step_ctr_tb_top.sv
module gray_step_ctr_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       adv = 1'b0;
    logic       qual = 1'b0;
    logic [1:0] st;
    logic       last_f;
    logic       mid_f;

    int n_cmp = 0;
    int n_bad = 0;
    logic [1:0] exp_st = 2'b00;

    always #2 clk = ~clk;

    gray_step_ctr dut_i (
        .clk_i   (clk),
        .rst_n_i (rst_n),
        .clr_i   (clr),
        .adv_i   (adv),
        .qual_i  (qual),
        .state_o (st),
        .last_o  (last_f),
        .mid_o   (mid_f)
    );

    function automatic logic [1:0] gray_succ(input logic [1:0] s);
        case (s)
            2'b00:   return 2'b01;
            2'b01:   return 2'b11;
            2'b11:   return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // apply inputs, clock once, sample after the edge
    task automatic step(input logic c, input logic a);
        @(negedge clk);
        clr = c;
        adv = a;
        @(posedge clk);
        #1;
        if (c) exp_st = 2'b00;
        else if (a) exp_st = gray_succ(exp_st);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        qual = 1'b1;
        #1;
        chk("R1 state in reset", {2'b0, st}, 4'h0);
        chk("R1 flags in reset", {2'b0, last_f, mid_f}, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        exp_st = 2'b00;
        chk("R1 state after release", {2'b0, st}, 4'h0);
        qual = 1'b0;
    endtask

    task automatic t_walk;
        logic [1:0] prev;
        for (int k = 0; k < 8; k++) begin
            prev = st;
            step(1'b0, 1'b1);
            chk("R2 advance order", {2'b0, st}, {2'b0, exp_st});
            chk("R6 one bit flips", 4'($countones(st ^ prev)), 4'd1);
        end
    endtask

    task automatic t_hold;
        for (int k = 0; k < 4; k++) begin
            step(1'b0, 1'b1);
            for (int j = 0; j < 3; j++) begin
                step(1'b0, 1'b0);
                chk("R3 idle hold", {2'b0, st}, {2'b0, exp_st});
            end
        end
    endtask

    task automatic t_clear;
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < k; j++) step(1'b0, 1'b1);
            step(1'b1, 1'b0);
            chk("R4 clear from state", {2'b0, st}, 4'h0);
        end
    endtask

    task automatic t_priority;
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0);
            for (int j = 0; j < k; j++) step(1'b0, 1'b1);
            step(1'b1, 1'b1);
            chk("R5 clear beats advance", {2'b0, st}, 4'h0);
        end
    endtask

    task automatic t_flags;
        step(1'b1, 1'b0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            clr = 1'b0;
            adv = 1'b0;
            qual = 1'b0;
            #1;
            chk("R7 last with qual low", {3'b0, last_f}, {3'b0, exp_st == 2'b11});
            chk("R8 mid with qual low", {3'b0, mid_f}, 4'h0);
            qual = 1'b1;
            #1;
            chk("R7 last with qual high", {3'b0, last_f}, {3'b0, exp_st == 2'b11});
            chk("R8 mid follows qual", {3'b0, mid_f}, {3'b0, exp_st == 2'b01});
            qual = 1'b0;
            #1;
            chk("R8 mid drops with qual", {3'b0, mid_f}, 4'h0);
            step(1'b0, 1'b1);
        end
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_walk();
        t_hold();
        t_clear();
        t_priority();
        t_flags();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule